// File: doc/BRIEF.md
# External Static Memory Controller

This block sits between a simple 32-bit on-chip request bus and an external asynchronous memory bus. A requester raises a request with an address, a write flag, write data and byte enables, and holds it until the controller returns a one-cycle ready pulse. Read data comes back with that pulse. Bits [26:24] of the address select one of eight banks, each with its own chip-select pin. The low 24 bits form the in-bank byte address.

Each bank holds a 25-bit configuration word, loaded through a one-cycle write port (`cfg_we`, `cfg_sel`, `cfg_wdata`). The word sets the external data width, chip-select polarity, read and write wait states, turnaround idle cycles, burst-ROM timing, write protection and read byte-lane behaviour. A sequencer runs each access as an optional turnaround phase followed by one or more strobe beats. A 32-bit request to a narrow bank is split into several beats, lowest address first.

Configuration word fields (bit positions): [1:0] width, [2] chip-select active-high, [7:3] read wait, [12:8] write wait, [16:13] turnaround, [17] burst enable, [22:18] subsequent-beat burst wait, [23] write protect, [24] read lane strobes.

Top module: `ext_mem_ctrl`

## Requirements
- R1: The bank index is req_addr[26:24]. In every cycle where mem_oe_n or mem_we_n is low, only that bank's chip select is active. When no strobe is low, every chip select is inactive, including during turnaround.
- R2: Config bit 2 set makes the bank's chip select active-high. Clear makes it active-low.
- R3: Width field [1:0] works as follows. Value 0 gives 8 bits: four beats on lane 0. Value 1 gives 16 bits: two beats on lanes 1:0. Value 2 or 3 gives 32 bits: one beat. mem_addr is the in-bank offset with bits [1:0] cleared, plus the beat number times the bytes per beat. Read beats are assembled little-endian into rsp_rdata.
- R4: Each beat holds its strobe for field+1 cycles, using read wait [7:3] or write wait [12:8]. rsp_ready is seen 1+T+S clock edges after the first edge with req_valid high. T is the turnaround cycle count and S is the total number of strobe cycles.
- R5: T is the new bank's field [16:13] plus 1 when the previous completed external access used another bank or the other direction. T is 0 for the first access after reset, and 0 when bank and direction repeat.
- R6: With burst bit 17 set, the first read beat uses the read wait. Each later read beat uses field [22:18]+1 cycles. Writes and non-burst banks always use their normal wait.
- R7: A write to a bank with bit 23 set drives no strobe and no chip select. It answers with rsp_ready and rsp_err on the first edge after acceptance. It does not count as a previous access for R5. Reads of the bank behave normally.
- R8: During read strobes, mem_bls_n is low on the bank's width lanes when bit 24 is set, and all high when it is clear.
- R9: During a write beat, mem_bls_n[i] is low exactly for each lane whose request byte enable belongs to that beat. That lane carries the matching write-data byte. mem_dout_en is high exactly in write strobe cycles.
- R10: After reset, every bank is 32-bit wide with an active-low chip select. Read, write and burst waits are 31, turnaround is 15, and burst, protection and read lane strobes are off. All chip selects and strobes are inactive.
- R11: rsp_ready is a single-cycle pulse. rsp_err is high only together with rsp_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Bank whose configuration is written |
| cfg_wdata | input | 32 | Configuration word, bits [24:0] used |
| req_valid | input | 1 | Request pending, held until rsp_ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address: [26:24] bank, [23:0] offset |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables for writes |
| rsp_ready | output | 1 | Access complete, one cycle |
| rsp_err | output | 1 | Write to protected bank, with rsp_ready |
| rsp_rdata | output | 32 | Assembled read data |
| mem_cs | output | 8 | Chip select per bank, polarity per bank |
| mem_addr | output | 24 | External byte address |
| mem_dout | output | 32 | External write data |
| mem_dout_en | output | 1 | Output enable for the data pins |
| mem_din | input | 32 | External read data |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_bls_n | output | 4 | Byte-lane strobes, active low |

## Verification
The bench runs each configured bank through a grid of offsets, with back-to-back reads and writes under the byte-enable patterns 1111, 0001, 1010 and 0110. Read data comes from a memory model whose byte value is a function of its address. Matching the expected word therefore separates correct beat ordering, address stepping and lane assembly from a swapped or missed beat at each width.

Bank order and direction changes alternate, so the exact latency count tells turnaround insertion apart from wait-state counting. Comparing burst and non-burst settings of one bank isolates the subsequent-beat count. A protected write placed between two same-bank reads shows whether it wrongly counts as a previous access.

// File: rtl/emc_pkg.sv
package emc_pkg;

   localparam int WAIT_W = 5;
   localparam int TURN_W = 4;

   // one bank's configuration word, bit 0 = width LSB
   typedef struct packed {
      logic              rd_lanes;
      logic              wprot;
      logic [WAIT_W-1:0] sub_wait;
      logic              burst;
      logic [TURN_W-1:0] turn;
      logic [WAIT_W-1:0] wr_wait;
      logic [WAIT_W-1:0] rd_wait;
      logic              cs_high;
      logic [1:0]        width;
   } bank_cfg_t;

   localparam int CFG_W = $bits(bank_cfg_t);

   localparam bank_cfg_t CFG_RESET = '{
      rd_lanes: 1'b0, wprot: 1'b0, sub_wait: '1, burst: 1'b0,
      turn: '1, wr_wait: '1, rd_wait: '1, cs_high: 1'b0, width: 2'd2};

   typedef enum logic [1:0] {ST_IDLE, ST_TURN, ST_BEAT, ST_RESP} seq_state_t;

   // log2 of the number of beats a full word takes on a bank
   function automatic logic [1:0] beats_lg(input logic [1:0] w);
      case (w)
         2'd0:    return 2'd2;
         2'd1:    return 2'd1;
         default: return 2'd0;
      endcase
   endfunction

endpackage

// File: rtl/emc_cfg_regs.sv
module emc_cfg_regs
   import emc_pkg::*;
#(
   parameter int NBANKS = 8,
   parameter int SEL_W  = $clog2(NBANKS),
   parameter int WORD_W = 32
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_we,
   input  logic [SEL_W-1:0]        cfg_sel,
   input  logic [WORD_W-1:0]       cfg_wdata,
   output logic [NBANKS*CFG_W-1:0] cfg_flat
);

   if (WORD_W <= CFG_W) begin : g_bad_word
      $error("emc_cfg_regs: configuration word too narrow");
   end

   logic unused_cfg_hi;
   assign unused_cfg_hi = ^cfg_wdata[WORD_W-1:CFG_W];

   for (genvar b = 0; b < NBANKS; b++) begin : g_bank
      bank_cfg_t q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= CFG_RESET;
         else if (cfg_we && cfg_sel == SEL_W'(b))
            q <= bank_cfg_t'(cfg_wdata[CFG_W-1:0]);
      end
      assign cfg_flat[b*CFG_W +: CFG_W] = q;
   end

endmodule

// File: rtl/emc_cs_drive.sv
module emc_cs_drive #(
   parameter int NBANKS = 8,
   parameter int SEL_W  = $clog2(NBANKS)
)(
   input  logic              active,
   input  logic [SEL_W-1:0]  sel,
   input  logic [NBANKS-1:0] pol_high,
   output logic [NBANKS-1:0] act_vec,
   output logic [NBANKS-1:0] cs_pin
);

   for (genvar b = 0; b < NBANKS; b++) begin : g_cs
      assign act_vec[b] = active && (sel == SEL_W'(b));
      assign cs_pin[b]  = pol_high[b] ? act_vec[b] : ~act_vec[b];
   end

endmodule

// File: rtl/emc_seq.sv
module emc_seq
   import emc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int OFFS_W = 24,
   parameter int SEL_W  = 3
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [DATA_W-1:0]   req_wdata,
   input  logic [DATA_W/8-1:0] req_be,
   input  bank_cfg_t           new_cfg,
   output logic                in_beat,
   output logic                cur_write,
   output logic [SEL_W-1:0]    cur_bank,
   output logic [OFFS_W-1:0]   ext_addr,
   output logic [DATA_W-1:0]   ext_dout,
   output logic [DATA_W/8-1:0] lane_act,
   input  logic [DATA_W-1:0]   ext_din,
   output logic                done,
   output logic                done_err,
   output logic [DATA_W-1:0]   rdata
);

   localparam int LANES   = DATA_W / 8;
   localparam int LANE_LG = $clog2(LANES);
   localparam int BEAT_W  = (LANE_LG > 0) ? LANE_LG : 1;
   localparam int CNT_W   = (WAIT_W > TURN_W) ? WAIT_W : TURN_W;

   seq_state_t          st_q;
   bank_cfg_t           cfg_q;
   logic                we_q, err_q;
   logic [SEL_W-1:0]    bank_q;
   logic [OFFS_W-1:0]   base_q;
   logic [DATA_W-1:0]   wd_q, rbuf_q;
   logic [LANES-1:0]    be_q;
   logic [BEAT_W-1:0]   beat_q, last_beat;
   logic [CNT_W-1:0]    cnt_q;
   logic                prev_v_q, prev_we_q;
   logic [SEL_W-1:0]    prev_bank_q;

   logic [SEL_W-1:0]    req_bank;
   logic [1:0]          lg;
   logic [LANES-1:0]    lane_mask, be_sh;
   int                  bpb, boff;

   logic unused_addr_hi;
   assign unused_addr_hi = ^req_addr[ADDR_W-1:OFFS_W+SEL_W];

   assign req_bank = req_addr[OFFS_W +: SEL_W];

   function automatic logic [CNT_W-1:0] beat_wait(input bank_cfg_t c, input logic wr,
                                                  input logic first);
      if (wr)                   return CNT_W'(c.wr_wait);
      else if (c.burst && !first) return CNT_W'(c.sub_wait);
      else                      return CNT_W'(c.rd_wait);
   endfunction

   // beat geometry from the latched width
   always_comb begin
      lg        = beats_lg(cfg_q.width);
      last_beat = BEAT_W'((1 << lg) - 1);
      bpb       = LANES >> lg;
      boff      = int'(beat_q) * bpb;
      lane_mask = LANES'((1 << bpb) - 1);
      be_sh     = LANES'(be_q >> boff);
      ext_addr  = (base_q & ~OFFS_W'(LANES - 1)) + OFFS_W'(boff);
      ext_dout  = wd_q >> (boff * 8);
      if (we_q)
         lane_act = be_sh & lane_mask;
      else
         lane_act = cfg_q.rd_lanes ? lane_mask : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         cfg_q       <= CFG_RESET;
         we_q        <= 1'b0;
         err_q       <= 1'b0;
         bank_q      <= '0;
         base_q      <= '0;
         wd_q        <= '0;
         be_q        <= '0;
         beat_q      <= '0;
         cnt_q       <= '0;
         rbuf_q      <= '0;
         prev_v_q    <= 1'b0;
         prev_we_q   <= 1'b0;
         prev_bank_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  cfg_q  <= new_cfg;
                  we_q   <= req_write;
                  bank_q <= req_bank;
                  base_q <= req_addr[OFFS_W-1:0];
                  wd_q   <= req_wdata;
                  be_q   <= req_be;
                  beat_q <= '0;
                  err_q  <= 1'b0;
                  if (req_write && new_cfg.wprot) begin
                     err_q <= 1'b1;
                     st_q  <= ST_RESP;
                  end else if (prev_v_q && (prev_bank_q != req_bank ||
                                            prev_we_q != req_write)) begin
                     cnt_q <= CNT_W'(new_cfg.turn);
                     st_q  <= ST_TURN;
                  end else begin
                     cnt_q <= beat_wait(new_cfg, req_write, 1'b1);
                     st_q  <= ST_BEAT;
                  end
               end
            end
            ST_TURN: begin
               if (cnt_q == '0) begin
                  cnt_q <= beat_wait(cfg_q, we_q, 1'b1);
                  st_q  <= ST_BEAT;
               end else begin
                  cnt_q <= cnt_q - CNT_W'(1);
               end
            end
            ST_BEAT: begin
               if (cnt_q == '0) begin
                  if (!we_q) begin
                     for (int i = 0; i < LANES; i++)
                        if (i < bpb) rbuf_q[(boff + i)*8 +: 8] <= ext_din[i*8 +: 8];
                  end
                  if (beat_q == last_beat) begin
                     st_q        <= ST_RESP;
                     prev_v_q    <= 1'b1;
                     prev_bank_q <= bank_q;
                     prev_we_q   <= we_q;
                  end else begin
                     beat_q <= beat_q + BEAT_W'(1);
                     cnt_q  <= beat_wait(cfg_q, we_q, 1'b0);
                  end
               end else begin
                  cnt_q <= cnt_q - CNT_W'(1);
               end
            end
            ST_RESP:  st_q <= ST_IDLE;
            default:  st_q <= ST_IDLE;
         endcase
      end
   end

   assign in_beat   = (st_q == ST_BEAT);
   assign cur_write = we_q;
   assign cur_bank  = bank_q;
   assign done      = (st_q == ST_RESP);
   assign done_err  = done && err_q;
   assign rdata     = rbuf_q;

endmodule

// File: rtl/ext_mem_ctrl.sv
module ext_mem_ctrl
   import emc_pkg::*;
#(
   parameter int NBANKS = 8,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int OFFS_W = 24,
   localparam int SEL_W = $clog2(NBANKS),
   localparam int LANES = DATA_W / 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [SEL_W-1:0]  cfg_sel,
   input  logic [31:0]       cfg_wdata,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_be,
   output logic              rsp_ready,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [NBANKS-1:0] mem_cs,
   output logic [OFFS_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dout,
   output logic              mem_dout_en,
   input  logic [DATA_W-1:0] mem_din,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [LANES-1:0]  mem_bls_n
);

   if (DATA_W != 32) begin : g_bad_data
      $error("ext_mem_ctrl: width encoding assumes a 32-bit data bus");
   end
   if (OFFS_W + SEL_W > ADDR_W) begin : g_bad_addr
      $error("ext_mem_ctrl: bank field does not fit in the address");
   end
   if (NBANKS != (1 << SEL_W)) begin : g_bad_banks
      $error("ext_mem_ctrl: bank count must be a power of two");
   end

   logic [NBANKS*CFG_W-1:0] cfg_flat;
   logic [NBANKS-1:0]       pol_high, cs_act;
   logic [SEL_W-1:0]        req_bank, cur_bank;
   bank_cfg_t               new_cfg;
   logic                    in_beat, cur_write;
   logic [LANES-1:0]        lane_act;

   emc_cfg_regs #(.NBANKS(NBANKS), .SEL_W(SEL_W), .WORD_W(32)) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cfg_flat(cfg_flat));

   assign req_bank = req_addr[OFFS_W +: SEL_W];
   always_comb new_cfg = bank_cfg_t'(cfg_flat[int'(req_bank)*CFG_W +: CFG_W]);

   for (genvar b = 0; b < NBANKS; b++) begin : g_pol
      bank_cfg_t one;
      assign one         = bank_cfg_t'(cfg_flat[b*CFG_W +: CFG_W]);
      assign pol_high[b] = one.cs_high;
   end

   emc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFS_W(OFFS_W), .SEL_W(SEL_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .new_cfg(new_cfg),
      .in_beat(in_beat), .cur_write(cur_write), .cur_bank(cur_bank),
      .ext_addr(mem_addr), .ext_dout(mem_dout), .lane_act(lane_act), .ext_din(mem_din),
      .done(rsp_ready), .done_err(rsp_err), .rdata(rsp_rdata));

   emc_cs_drive #(.NBANKS(NBANKS), .SEL_W(SEL_W)) u_cs (
      .active(in_beat), .sel(cur_bank), .pol_high(pol_high),
      .act_vec(cs_act), .cs_pin(mem_cs));

   assign mem_oe_n    = ~(in_beat & ~cur_write);
   assign mem_we_n    = ~(in_beat &  cur_write);
   assign mem_dout_en = in_beat & cur_write;
   assign mem_bls_n   = in_beat ? ~lane_act : '1;

endmodule

// File: rtl/emc_checker.sv
module emc_checker #(
   parameter int NBANKS = 8
)(
   input logic              clk,
   input logic              rst_n,
   input logic              rsp_ready,
   input logic              rsp_err,
   input logic              mem_oe_n,
   input logic              mem_we_n,
   input logic              mem_dout_en,
   input logic [NBANKS-1:0] cs_act
);

   assert_cs_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cs_act));

   assert_cs_with_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_oe_n || !mem_we_n) |-> ($countones(cs_act) == 1));

   assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_oe_n && !mem_we_n));

   assert_ready_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ready |=> !rsp_ready);

   assert_err_with_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> rsp_ready);

   assert_prot_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> ($past(mem_we_n) && $past(mem_oe_n)));

   assert_dout_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dout_en |-> !mem_we_n);

endmodule

bind ext_mem_ctrl emc_checker #(.NBANKS(NBANKS)) u_chk (
   .clk(clk), .rst_n(rst_n), .rsp_ready(rsp_ready), .rsp_err(rsp_err),
   .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dout_en(mem_dout_en),
   .cs_act(cs_act));

// File: tb/ext_mem_ctrl_test.sv
`timescale 1ns/1ps
module ext_mem_ctrl_test;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [31:0] req_addr = '0, req_wdata = '0;
   logic [3:0]  req_be = '0;
   logic        rsp_ready, rsp_err;
   logic [31:0] rsp_rdata;
   logic [7:0]  mem_cs;
   logic [23:0] mem_addr;
   logic [31:0] mem_dout, mem_din;
   logic        mem_dout_en, mem_oe_n, mem_we_n;
   logic [3:0]  mem_bls_n;

   ext_mem_ctrl uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_be(req_be), .rsp_ready(rsp_ready), .rsp_err(rsp_err),
      .rsp_rdata(rsp_rdata), .mem_cs(mem_cs), .mem_addr(mem_addr), .mem_dout(mem_dout),
      .mem_dout_en(mem_dout_en), .mem_din(mem_din), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n), .mem_bls_n(mem_bls_n));

   always #2 clk = ~clk;   // 250 MHz

   int vectors = 0, errors = 0;
   int c_width[8], c_pol[8], c_rd[8], c_wr[8], c_turn[8], c_burst[8], c_sub[8], c_wp[8], c_lanes[8];
   bit have_prev = 0, prev_we = 0;
   int prev_bank = 0;
   int exp_bank = 0, cs_bad = 0, lane_bad = 0, rd_cyc = 0, wr_cyc = 0;
   bit mon_en = 0;
   logic [7:0] wmem [int];

   function automatic logic [7:0] pat(input logic [23:0] a);
      return (a[7:0] * 8'd37) ^ a[15:8] ^ a[23:16] ^ 8'hA5;
   endfunction

   function automatic logic [3:0] wmask(input int w);
      return (w == 0) ? 4'h1 : (w == 1) ? 4'h3 : 4'hF;
   endfunction

   assign mem_din = {pat(mem_addr + 24'd3), pat(mem_addr + 24'd2),
                     pat(mem_addr + 24'd1), pat(mem_addr)};

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   endtask

   // bus monitor: chip selects, lane strobes, captured writes
   always @(negedge clk) begin
      logic e;
      if (mon_en && rst_n) begin
         if (!mem_oe_n || !mem_we_n) begin
            for (int b = 0; b < 8; b++) begin
               e = (b == exp_bank) ? (c_pol[b] != 0) : (c_pol[b] == 0);
               if (mem_cs[b] !== e) cs_bad++;
            end
         end else begin
            for (int b = 0; b < 8; b++)
               if (mem_cs[b] !== (c_pol[b] == 0)) cs_bad++;
         end
         if (!mem_oe_n) begin
            rd_cyc++;
            if (mem_bls_n !== (c_lanes[exp_bank] != 0 ? ~wmask(c_width[exp_bank]) : 4'hF))
               lane_bad++;
         end
         if (!mem_we_n) begin
            wr_cyc++;
            if (!mem_dout_en) lane_bad++;
            for (int i = 0; i < 4; i++)
               if (!mem_bls_n[i]) wmem[int'(mem_addr) + i] = mem_dout[8*i +: 8];
         end else if (mem_dout_en) lane_bad++;
      end
   end

   task automatic set_cfg(input int b, input int w, input int pol, input int rd, input int wr,
                          input int turn, input int burst, input int sub, input int wp,
                          input int lanes);
      c_width[b] = w; c_pol[b] = pol; c_rd[b] = rd; c_wr[b] = wr; c_turn[b] = turn;
      c_burst[b] = burst; c_sub[b] = sub; c_wp[b] = wp; c_lanes[b] = lanes;
      cfg_sel   = 3'(b);
      cfg_wdata = 32'((lanes << 24) | (wp << 23) | (sub << 18) | (burst << 17) |
                      (turn << 13) | (wr << 8) | (rd << 3) | (pol << 2) | w);
      cfg_we    = 1'b1;
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   task automatic txn(input bit we, input int bank, input logic [23:0] off,
                      input logic [31:0] wd, input logic [3:0] be);
      int nb, t, s, lat, exp_lat;
      bit prot;
      logic [23:0] a;
      logic [31:0] exp_rd;
      string tag;
      a    = {off[23:2], 2'b00};
      prot = we && (c_wp[bank] != 0);
      nb   = (c_width[bank] == 0) ? 4 : (c_width[bank] == 1) ? 2 : 1;
      t = 0; s = 0;
      if (!prot) begin
         if (have_prev && (prev_bank != bank || prev_we != we)) t = c_turn[bank] + 1;
         for (int k = 0; k < nb; k++)
            s += we ? c_wr[bank] + 1
                    : ((c_burst[bank] != 0 && k > 0) ? c_sub[bank] + 1 : c_rd[bank] + 1);
      end
      exp_lat = 1 + t + s;
      exp_rd  = {pat(a + 24'd3), pat(a + 24'd2), pat(a + 24'd1), pat(a)};
      wmem.delete();
      cs_bad = 0; lane_bad = 0; rd_cyc = 0; wr_cyc = 0; exp_bank = bank; mon_en = 1;
      req_valid = 1'b1; req_write = we; req_addr = {5'd0, 3'(bank), off};
      req_wdata = wd; req_be = be;
      lat = 0;
      do begin
         @(posedge clk); lat++; @(negedge clk);
      end while (!rsp_ready && lat < 2000);
      if (prot)                                   tag = "R7";
      else if (bank >= 5)                         tag = "R10";
      else if (t > 0)                             tag = "R5";
      else if (!we && c_burst[bank] != 0 && nb > 1) tag = "R6";
      else                                        tag = "R4";
      check(lat == exp_lat, tag, "latency", lat, exp_lat);
      check(rsp_err == prot, "R7", "error flag", rsp_err, prot);
      check(cs_bad == 0, (c_pol[bank] != 0) ? "R2" : "R1", "chip select cycles", cs_bad, 0);
      if (prot) begin
         check(wr_cyc + rd_cyc == 0, "R7", "strobes on protected write", wr_cyc + rd_cyc, 0);
      end else if (we) begin
         check(wr_cyc == s && rd_cyc == 0, "R4", "write strobe cycles", wr_cyc, s);
         check(lane_bad == 0, "R9", "data enable", lane_bad, 0);
         for (int i = 0; i < 4; i++) begin
            if (be[i])
               check(wmem.exists(int'(a) + i) && wmem[int'(a) + i] == wd[8*i +: 8], "R9",
                     "written byte", wmem.exists(int'(a) + i) ? wmem[int'(a) + i] : 8'hxx,
                     wd[8*i +: 8]);
            else
               check(!wmem.exists(int'(a) + i), "R9", "disabled byte written", i, -1);
         end
      end else begin
         check(rd_cyc == s && wr_cyc == 0, "R4", "read strobe cycles", rd_cyc, s);
         check(rsp_rdata == exp_rd, "R3", "read data", rsp_rdata, exp_rd);
         check(lane_bad == 0, "R8", "read lane strobes", lane_bad, 0);
      end
      req_valid = 1'b0; mon_en = 0;
      @(negedge clk);
      check(!rsp_ready, "R11", "ready pulse width", rsp_ready, 0);
      if (!prot) begin have_prev = 1; prev_bank = bank; prev_we = we; end
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [23:0] offs [4];
      logic [3:0]  bes  [4];
      int          banks[5];
      offs = '{24'h000000, 24'h000106, 24'hFFFFFC, 24'h12345A};
      bes  = '{4'hF, 4'h1, 4'hA, 4'h6};
      banks = '{0, 1, 2, 3, 4};
      for (int b = 0; b < 8; b++) begin
         c_width[b] = 2; c_pol[b] = 0; c_rd[b] = 31; c_wr[b] = 31; c_turn[b] = 15;
         c_burst[b] = 0; c_sub[b] = 31; c_wp[b] = 0; c_lanes[b] = 0;
      end
      repeat (3) @(negedge clk);
      // R10: idle pins during and after reset
      check(mem_cs == 8'hFF, "R10", "chip selects in reset", mem_cs, 8'hFF);
      check(mem_oe_n && mem_we_n && mem_bls_n == 4'hF, "R10", "strobes in reset",
            {mem_oe_n, mem_we_n, mem_bls_n}, 6'h3F);
      check(!rsp_ready && !rsp_err, "R11", "ready in reset", rsp_ready, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // untouched bank: default timing and width
      txn(1'b0, 5, 24'h000040, '0, 4'h0);
      txn(1'b1, 5, 24'h000044, 32'hCAFE_F00D, 4'hF);
      set_cfg(0, 2, 0, 1, 0, 0, 0, 0, 0, 1);
      set_cfg(1, 1, 1, 2, 1, 2, 1, 0, 0, 0);
      set_cfg(2, 0, 0, 3, 2, 1, 1, 1, 0, 1);
      set_cfg(3, 0, 1, 1, 3, 3, 0, 0, 0, 0);
      set_cfg(4, 3, 0, 0, 0, 0, 0, 0, 1, 1);
      foreach (banks[j]) begin
         foreach (offs[k]) begin
            txn(1'b0, banks[j], offs[k], '0, 4'h0);
            txn(1'b0, banks[j], offs[k], '0, 4'h0);
            foreach (bes[m])
               txn(1'b1, banks[j], offs[k], 32'h5A00_0000 ^ {offs[k], 8'(m)} ^ 32'h0F1E_2D3C,
                   bes[m]);
         end
      end
      // protected write between same-bank reads adds no turnaround (R7, R5)
      txn(1'b0, 0, 24'h000010, '0, 4'h0);
      txn(1'b1, 4, 24'h000010, 32'h1234_5678, 4'hF);
      txn(1'b0, 0, 24'h000014, '0, 4'h0);
      // same 8-bit bank with burst off: every beat uses the read wait (R6)
      set_cfg(2, 0, 0, 3, 2, 1, 0, 1, 0, 1);
      txn(1'b0, 2, 24'h000200, '0, 4'h0);
      txn(1'b0, 2, 24'h000204, '0, 4'h0);
      finish_run();
   end

endmodule